// File: doc/BRIEF.md
# Level-Emulating Interrupt Aggregator

This block gathers eleven interrupt input lines into one interrupt message stream. It watches every line for a change of state. A change on an implemented line is latched into a pending register. When the line is also enabled in the mask register, the change is latched into a request register as well. The first enabled change that arrives while no message is outstanding starts one outbound message. The message carries the address and data taken from a programmed target word.

Software services the message by reading the request register, which clears it. It can then read the live level register to check whether any enabled line is still asserted. This lets software emulate level-triggered behaviour on top of messaging that reacts only to changes. Lines 0 to 5 are the shared PCI interrupt pins A to F, line 6 is an external bus interrupt, line 7 is a default line and line 10 is the serial port.

The host reaches the registers through a simple one-cycle register port. The outbound message uses a valid/ready handshake. A message stays presented, unchanged, until the host side accepts it. While it waits, later enabled changes only accumulate in the request register.

Top module: `irq_level_agg`

## Requirements
- R1: After reset every register reads zero, `msg_valid` is low and `rd_valid` is low.
- R2: The level register at offset 0x028 shows all eleven input lines, each sampled one cycle after it changes. Reads of any register never alter it.
- R3: Only the lines in implemented mask 0x5FF (bits 0–8 and 10) latch into the request and pending registers. Bit 9 and bits 11–31 of those registers read zero.
- R4: The request register at offset 0x00C latches a rising or a falling change on an enabled, implemented line. A read returns the latched bits and clears them.
- R5: The pending register at offset 0x01C latches changes on implemented lines whatever the mask. A read returns and clears it, and leaves the request and level registers unchanged.
- R6: The mask register at offset 0x018 is read/write, and a 1 enables a line. Only the implemented bits (0x5FF) are stored.
- R7: An enabled change with no message outstanding raises `msg_valid` one cycle later. `msg_addr` is the target word with its low 5 bits cleared, and `msg_data` is the target's low 5 bits.
- R8: Once raised, `msg_valid` stays high, with `msg_addr` and `msg_data` unchanged, until a cycle in which `msg_ready` is high.
- R9: After the handshake `msg_valid` falls. Enabled changes made while the message was outstanding merge into the request register and produce no second message.
- R10: A line that is already high when its mask bit is set produces neither a message nor a request bit.
- R11: The target register at 0x004 and the control register at 0x024 are plain 32-bit read/write registers. Writes to the request, pending and level offsets have no effect.
- R12: A read returns its data on `rd_data`, with `rd_valid` high, in the cycle after the request. An unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq_lines | input | 11 | Interrupt input lines |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 5 | Message data word |

## Verification
The assertions check four behaviours on every cycle: a waiting message holds its payload, a message falls after its handshake, unimplemented bits read zero, and read data appears only one cycle after a read. They also check that no message starts without an enabled change in the cycle before. The bench scenarios show the rest. These are the read-to-clear behaviour, the independence of the pending and level registers, the merging of changes while a message waits, and the case of a line asserted before it is unmasked. The bench also checks that each accepted message matches the programmed target.

// File: rtl/irq_level_agg_pkg.sv
package irq_level_agg_pkg;
  localparam logic [11:0] OFS_TGT  = 12'h004;
  localparam logic [11:0] OFS_REQ  = 12'h00C;
  localparam logic [11:0] OFS_MASK = 12'h018;
  localparam logic [11:0] OFS_PEND = 12'h01C;
  localparam logic [11:0] OFS_CTRL = 12'h024;
  localparam logic [11:0] OFS_LVL  = 12'h028;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TGT, SEL_REQ, SEL_MASK, SEL_PEND, SEL_CTRL, SEL_LVL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [11:0] a);
    case (a)
      OFS_TGT:  return SEL_TGT;
      OFS_REQ:  return SEL_REQ;
      OFS_MASK: return SEL_MASK;
      OFS_PEND: return SEL_PEND;
      OFS_CTRL: return SEL_CTRL;
      OFS_LVL:  return SEL_LVL;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_level_agg_detect.sv
module irq_level_agg_detect #(
  parameter int          NUM_IN    = 11,
  parameter logic [10:0] IMPL_MASK = 11'h5FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] lines_i,
  input  logic [NUM_IN-1:0] mask_i,
  output logic [NUM_IN-1:0] level_o,
  output logic [NUM_IN-1:0] chg_raw_o,
  output logic [NUM_IN-1:0] chg_en_o
);
  logic [NUM_IN-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= lines_i;
  end

  assign level_o   = level_q;
  assign chg_raw_o = (lines_i ^ level_q) & IMPL_MASK[NUM_IN-1:0];
  assign chg_en_o  = chg_raw_o & mask_i;
endmodule

// File: rtl/irq_level_agg_latch.sv
module irq_level_agg_latch #(
  parameter int NUM_IN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] set_i,
  input  logic              clr_i,
  output logic [NUM_IN-1:0] q_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_i)    bit_q <= 1'b0;
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_level_agg_msg.sv
module irq_level_agg_msg #(
  parameter int DW  = 32,
  parameter int MDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire_i,
  input  logic [DW-1:0]  target_i,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [DW-1:0]  msg_addr,
  output logic [MDW-1:0] msg_data
);
  logic           valid_q;
  logic [DW-1:0]  addr_q;
  logic [MDW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!valid_q) begin
      if (fire_i) begin
        valid_q <= 1'b1;
        addr_q  <= {target_i[DW-1:MDW], {MDW{1'b0}}};
        data_q  <= target_i[MDW-1:0];
      end
    end else if (msg_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_level_agg_pkg::*;
#(
  parameter int          NUM_IN    = 11,
  parameter logic [10:0] IMPL_MASK = 11'h5FF,
  parameter int          DW        = 32,
  parameter int          MDW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [NUM_IN-1:0] irq_lines,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DW-1:0]     msg_addr,
  output logic [MDW-1:0]    msg_data
);
  localparam logic [NUM_IN-1:0] IMPL = IMPL_MASK[NUM_IN-1:0];

  reg_sel_e          sel;
  logic              rd_req, wr_req;
  logic [DW-1:0]     tgt_q, ctrl_q, rd_mux, rd_q;
  logic [NUM_IN-1:0] mask_q, lvl_q, chg_raw, chg_en, req_q, pend_q;
  logic              rdv_q;

  assign sel    = decode_ofs(reg_addr);
  assign rd_req = reg_en && !reg_we;
  assign wr_req = reg_en && reg_we;

  irq_level_agg_detect #(.NUM_IN(NUM_IN), .IMPL_MASK(IMPL_MASK)) u_detect (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .mask_i(mask_q),
    .level_o(lvl_q), .chg_raw_o(chg_raw), .chg_en_o(chg_en)
  );

  irq_level_agg_latch #(.NUM_IN(NUM_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .set_i(chg_en),
    .clr_i(rd_req && sel == SEL_REQ), .q_o(req_q)
  );

  irq_level_agg_latch #(.NUM_IN(NUM_IN)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(chg_raw),
    .clr_i(rd_req && sel == SEL_PEND), .q_o(pend_q)
  );

  irq_level_agg_msg #(.DW(DW), .MDW(MDW)) u_msg (
    .clk(clk), .rst_n(rst_n), .fire_i(|chg_en), .target_i(tgt_q),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_req) begin
      case (sel)
        SEL_TGT:  tgt_q  <= reg_wdata;
        SEL_CTRL: ctrl_q <= reg_wdata;
        SEL_MASK: mask_q <= reg_wdata[NUM_IN-1:0] & IMPL;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_TGT:  rd_mux = tgt_q;
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_MASK: rd_mux = DW'(mask_q);
      SEL_REQ:  rd_mux = DW'(req_q);
      SEL_PEND: rd_mux = DW'(pend_q);
      SEL_LVL:  rd_mux = DW'(lvl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rdv_q <= rd_req;
      rd_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/irq_level_agg_chk.sv
module irq_level_agg_chk #(
  parameter int          NUM_IN    = 11,
  parameter logic [10:0] IMPL_MASK = 11'h5FF,
  parameter int          DW        = 32,
  parameter int          MDW       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [11:0]       reg_addr,
  input logic              rd_valid,
  input logic [DW-1:0]     rd_data,
  input logic [NUM_IN-1:0] irq_lines,
  input logic [NUM_IN-1:0] lvl_q,
  input logic [NUM_IN-1:0] mask_q,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [DW-1:0]     msg_addr,
  input logic [MDW-1:0]    msg_data
);
  localparam logic [DW-1:0] IMPL_W = DW'(IMPL_MASK[NUM_IN-1:0]);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R8

  AST_MSG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid); // R9

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && ($past(reg_addr) == 12'h00C || $past(reg_addr) == 12'h01C)
      |-> (rd_data & ~IMPL_W) == '0); // R3

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(reg_en && !reg_we)); // R12

  AST_MSG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|((irq_lines ^ lvl_q) & mask_q))); // R7
endmodule

bind irq_level_agg irq_level_agg_chk #(
  .NUM_IN(NUM_IN), .IMPL_MASK(IMPL_MASK), .DW(DW), .MDW(MDW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .irq_lines(irq_lines), .lvl_q(lvl_q), .mask_q(mask_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/irq_level_agg_bench.sv
`timescale 1ns/1ps
module irq_level_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [10:0] irq_lines = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [4:0]  msg_data;

  int errors = 0, checks = 0, rx_count = 0;
  logic [36:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_level_agg u_irq_level_agg (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_lines(irq_lines), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(tag, rd_data, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard driver side: set lines and queue the message this change should produce
  task automatic drive_lines(input logic [10:0] v, input bit expect_msg);
    @(negedge clk);
    irq_lines = v;
    if (expect_msg) exp_q.push_back({5'h07, 32'h1234_5660});
  endtask

  // Monitor: compare every accepted message against the queue
  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      rx_count++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected message actual=%h/%h expected=none", msg_addr, msg_data);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        check("R7 msg_addr", msg_addr, e[31:0]);
        check("R7 msg_data", 32'(msg_data), 32'(e[36:32]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 msg_valid", 32'(msg_valid), 32'd0);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    rd_chk("R1 tgt", 12'h004, 32'h0);
    rd_chk("R1 mask", 12'h018, 32'h0);
    rd_chk("R1 req", 12'h00C, 32'h0);
    rd_chk("R1 pend", 12'h01C, 32'h0);
    rd_chk("R1 lvl", 12'h028, 32'h0);
    rd_chk("R1 ctrl", 12'h024, 32'h0);

    // R11 plain registers
    wr(12'h004, 32'h1234_5667);
    rd_chk("R11 tgt", 12'h004, 32'h1234_5667);
    wr(12'h024, 32'h0);
    rd_chk("R11 ctrl zero", 12'h024, 32'h0);
    wr(12'h024, 32'hA5A5_0F0F);
    rd_chk("R11 ctrl", 12'h024, 32'hA5A5_0F0F);
    // R6 mask stores implemented bits only
    wr(12'h018, 32'hFFFF_FFFF);
    rd_chk("R6 mask", 12'h018, 32'h0000_05FF);

    // R7 basic message, R2/R4/R5 registers
    msg_ready = 1'b1;
    drive_lines(11'h001, 1'b1);
    wait_cyc(3);
    rd_chk("R2 lvl", 12'h028, 32'h001);
    rd_chk("R5 pend", 12'h01C, 32'h001);
    rd_chk("R4 req kept after pend read", 12'h00C, 32'h001);
    rd_chk("R4 req cleared", 12'h00C, 32'h0);
    rd_chk("R5 pend cleared", 12'h01C, 32'h0);
    rd_chk("R2 lvl after reads", 12'h028, 32'h001);

    // R8 back-pressure, R9 merge
    msg_ready = 1'b0;
    drive_lines(11'h003, 1'b1);
    wait_cyc(4);
    check("R8 valid held", 32'(msg_valid), 32'd1);
    check("R8 addr held", msg_addr, 32'h1234_5660);
    drive_lines(11'h007, 1'b0);
    wait_cyc(3);
    check("R8 valid still held", 32'(msg_valid), 32'd1);
    msg_ready = 1'b1;
    wait_cyc(4);
    check("R9 valid dropped", 32'(msg_valid), 32'd0);
    rd_chk("R9 merged req", 12'h00C, 32'h006);

    // R3 unimplemented bit 9
    drive_lines(11'h207, 1'b0);
    wait_cyc(3);
    rd_chk("R3 req bit9", 12'h00C, 32'h0);
    rd_chk("R3 pend bit9 absent", 12'h01C, 32'h006);
    rd_chk("R2 lvl bit9", 12'h028, 32'h207);

    // R10 asserted before unmask
    wr(12'h018, 32'h0);
    drive_lines(11'h247, 1'b0);
    wait_cyc(2);
    rd_chk("R5 pend ignores mask", 12'h01C, 32'h040);
    wr(12'h018, 32'h040);
    wait_cyc(3);
    check("R10 no message", 32'(msg_valid), 32'd0);
    rd_chk("R10 no req", 12'h00C, 32'h0);
    // R4 falling change on enabled line
    drive_lines(11'h207, 1'b1);
    wait_cyc(3);
    rd_chk("R4 falling req", 12'h00C, 32'h040);

    // R11 writes to read-only offsets have no effect
    drive_lines(11'h247, 1'b1);
    wait_cyc(3);
    wr(12'h00C, 32'h0);
    wr(12'h01C, 32'h0);
    wr(12'h028, 32'h0);
    rd_chk("R11 req unaffected", 12'h00C, 32'h040);
    rd_chk("R11 pend unaffected", 12'h01C, 32'h040);
    rd_chk("R11 lvl unaffected", 12'h028, 32'h247);

    // R12 unmapped read
    rd_chk("R12 unmapped", 12'h100, 32'h0);

    wait_cyc(4);
    check("R7 queue drained", 32'(exp_q.size()), 32'd0);
    check("R7 message count", 32'(rx_count), 32'd4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule